// File: doc/BRIEF.md
# Multi-Lane Serial Flash PIO Shifter

A register-programmed shift engine for a serial flash bus. Each command moves one to four bytes in single, dual or quad lane mode. Software writes a command register that gives the byte count and the lane width. A write of a data word, or a write of the read command, then starts one burst on the bus. Chip selects come from a separate register and are held between bursts. Software can therefore build a full flash transaction, with opcode, address, dummy and data phases, out of several bursts inside one chip-select window.

The serial clock idles low and runs at half the system clock. Outgoing bits change while the clock is low, and incoming bits are sampled on its rising edge. A busy flag in the status register tells software when the next command may be written. The data of a completed read is held in a read-data register until the next read finishes.

Register byte offsets on the 32-bit register bus:

| Offset | Register |
|---|---|
| 0x00 | chip select |
| 0x04 | write command |
| 0x08 | read command |
| 0x0C | write data |
| 0x10 | read data |
| 0x14 | status |

Top module: `spi_pio_top`

## Requirements
- R1: After reset both chip selects are high, SCK is low, all IO output enables are 0, the status reads 0 and the read-data register reads 0.
- R2: Chip select n (`cs_no[n]`) follows bit 4*n of the chip-select register, with 0 meaning asserted. Writes to this register take effect at any time, including during a burst. The register reads back as all ones except bits 0 and 4, which show the stored values.
- R3: A write to write data (0x0C) while idle shifts out (len+1) bytes, where len is command bits [1:0]. The bytes are taken from bits 31:24 downward, and each byte goes out MSB first.
- R4: The width code in command bits [29:28] selects the lanes. Code 0 is single and drives IO0, with enable 0001. Code 1 is dual and drives IO1:IO0, with the earlier bit on IO1 and enable 0011. Codes 2 and 3 are quad and drive IO3:IO0, with the earliest bit on IO3 and enable 1111.
- R5: SCK is low when idle. Each SCK period is two system clocks: the first is low and the second is high. A burst gives (len+1)*8/lanes pulses.
- R6: Status bit 3 reads 1 from the cycle after the starting write for exactly 2*(len+1)*8/lanes cycles, and 0 otherwise. All other status bits are 0.
- R7: A write to read command (0x08) while idle stores the command and starts a read with the count and width just written. During the read, and whenever the engine is idle, all IO output enables are 0. A single-lane read samples IO1. Dual samples IO1:IO0 and quad samples IO3:IO0, with the higher lane holding the earlier bit.
- R8: When a read ends, the read-data register (0x10) takes the received bytes, the first received byte in bits 7:0, with the upper unused bytes 0. It keeps this value until the next read completes.
- R9: Writes to write command, read command or write data during a burst are ignored. The burst continues unchanged, no new burst starts, and the command registers keep their values.
- R10: The command registers read back bits [29:28] and [1:0] as stored, and all other bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 2 | Active-low chip selects |
| io_o | output | 4 | IO lane output values |
| io_oe_o | output | 4 | IO lane output enables |
| io_i | input | 4 | IO lane input values |

## Verification
The hardest case to reach from the ports is a command or data write that lands in the middle of a burst. The bench issues write-command, write-data, read-command and chip-select writes back to back while a long single-lane burst is running. The behavioural model keeps checking the lanes cycle by cycle through to the end, and then reads the command register back. To catch lane mix-ups, the bench drives the opposite value or a fixed junk value on every IO input that the current mode should ignore.

// File: rtl/spi_pio_pkg.sv
package spi_pio_pkg;
  localparam int IO_W   = 4;
  localparam int LEN_W  = 2;
  localparam int BUSY_BIT = 3;

  localparam logic [7:0] OFF_CS     = 8'h00;
  localparam logic [7:0] OFF_WCMD   = 8'h04;
  localparam logic [7:0] OFF_RCMD   = 8'h08;
  localparam logic [7:0] OFF_WDATA  = 8'h0C;
  localparam logic [7:0] OFF_RDATA  = 8'h10;
  localparam logic [7:0] OFF_STATUS = 8'h14;

  typedef enum logic [1:0] {
    W_SINGLE = 2'd0,
    W_DUAL   = 2'd1,
    W_QUAD   = 2'd2,
    W_QUAD_X = 2'd3
  } width_e;

  typedef struct packed {
    width_e            width;
    logic [LEN_W-1:0]  len;
  } cmd_t;

  function automatic int lane_shift(width_e w);
    case (w)
      W_SINGLE: return 0;
      W_DUAL:   return 1;
      default:  return 2;
    endcase
  endfunction

  function automatic logic [IO_W-1:0] lane_mask(width_e w);
    case (w)
      W_SINGLE: return 4'b0001;
      W_DUAL:   return 4'b0011;
      default:  return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/spi_pio_regs.sv
module spi_pio_regs
  import spi_pio_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int NUM_CS    = 2,
  parameter int CS_STRIDE = 4,
  parameter int WID_LSB   = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              busy_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic              tx_start_o,
  output logic              rx_start_o,
  output cmd_t              start_cmd_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic [NUM_CS-1:0] cs_no
);
  cmd_t              wcmd_q, rcmd_q, new_cmd;
  logic [NUM_CS-1:0] cs_q;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_cs, hit_wcmd, hit_rcmd, hit_wdata;

  assign hit_cs    = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_CS));
  assign hit_wcmd  = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_WCMD))  && !busy_i;
  assign hit_rcmd  = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_RCMD))  && !busy_i;
  assign hit_wdata = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_WDATA)) && !busy_i;

  assign new_cmd.width = width_e'(reg_wdata_i[WID_LSB +: 2]);
  assign new_cmd.len   = reg_wdata_i[LEN_W-1:0];

  assign tx_start_o  = hit_wdata;
  assign rx_start_o  = hit_rcmd;
  assign start_cmd_o = hit_rcmd ? new_cmd : wcmd_q;
  assign tx_word_o   = reg_wdata_i;
  assign cs_no       = cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcmd_q  <= '0;
      rcmd_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (hit_wcmd) wcmd_q <= new_cmd;
      if (hit_rcmd) rcmd_q <= new_cmd;
      if (rx_done_i) rdata_q <= rx_word_i;
    end
  end

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_q[c] <= 1'b1;
      else if (hit_cs) cs_q[c] <= reg_wdata_i[c*CS_STRIDE];
    end
  end

  function automatic logic [DATA_W-1:0] cmd_word(cmd_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[WID_LSB +: 2]   = c.width;
    w[LEN_W-1:0]      = c.len;
    return w;
  endfunction

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(OFF_CS): begin
        reg_rdata_o = '1;
        for (int c = 0; c < NUM_CS; c++) reg_rdata_o[c*CS_STRIDE] = cs_q[c];
      end
      ADDR_W'(OFF_WCMD):   reg_rdata_o = cmd_word(wcmd_q);
      ADDR_W'(OFF_RCMD):   reg_rdata_o = cmd_word(rcmd_q);
      ADDR_W'(OFF_RDATA):  reg_rdata_o = rdata_q;
      ADDR_W'(OFF_STATUS): reg_rdata_o[BUSY_BIT] = busy_i;
      default:             reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_pio_shift.sv
module spi_pio_shift
  import spi_pio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_start_i,
  input  logic              rx_start_i,
  input  cmd_t              start_cmd_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic [IO_W-1:0]   io_i,
  output logic              sck_o,
  output logic [IO_W-1:0]   io_o,
  output logic [IO_W-1:0]   io_oe_o,
  output logic              busy_o,
  output logic              rx_mode_o,
  output logic              rx_done_o,
  output logic [DATA_W-1:0] rx_raw_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int SLOT_W = $clog2(DATA_W + 1);

  logic              busy_q, rx_q, phase_q;
  logic [SLOT_W-1:0] cnt_q, last_q, slots_m1;
  width_e            wid_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] sr_q;
  logic [IO_W-1:0]   drive;

  always_comb begin
    int nb;
    nb = ((int'(start_cmd_i.len) + 1) * 8) >> lane_shift(start_cmd_i.width);
    slots_m1 = SLOT_W'(nb - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rx_q    <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      last_q  <= '0;
      wid_q   <= W_SINGLE;
      len_q   <= '0;
      sr_q    <= '0;
    end else if (tx_start_i || rx_start_i) begin
      busy_q  <= 1'b1;
      rx_q    <= rx_start_i;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      last_q  <= slots_m1;
      wid_q   <= start_cmd_i.width;
      len_q   <= start_cmd_i.len;
      sr_q    <= tx_start_i ? tx_word_i : '0;
    end else if (busy_q) begin
      if (!phase_q) begin
        // rising SCK: sample inbound lanes
        phase_q <= 1'b1;
        if (rx_q) begin
          case (wid_q)
            W_SINGLE: sr_q <= {sr_q[DATA_W-2:0], io_i[1]};
            W_DUAL:   sr_q <= {sr_q[DATA_W-3:0], io_i[1:0]};
            default:  sr_q <= {sr_q[DATA_W-5:0], io_i};
          endcase
        end
      end else begin
        // falling SCK: advance outbound lanes
        phase_q <= 1'b0;
        cnt_q   <= cnt_q + 1'b1;
        if (!rx_q) begin
          case (wid_q)
            W_SINGLE: sr_q <= {sr_q[DATA_W-2:0], 1'b0};
            W_DUAL:   sr_q <= {sr_q[DATA_W-3:0], 2'b0};
            default:  sr_q <= {sr_q[DATA_W-5:0], 4'b0};
          endcase
        end
        if (cnt_q == last_q) busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (wid_q)
      W_SINGLE: drive = {3'b000, sr_q[DATA_W-1]};
      W_DUAL:   drive = {2'b00, sr_q[DATA_W-1 -: 2]};
      default:  drive = sr_q[DATA_W-1 -: 4];
    endcase
  end

  assign sck_o     = busy_q && phase_q;
  assign io_oe_o   = (busy_q && !rx_q) ? lane_mask(wid_q) : '0;
  assign io_o      = drive & io_oe_o;
  assign busy_o    = busy_q;
  assign rx_mode_o = rx_q;
  assign rx_done_o = busy_q && rx_q && phase_q && (cnt_q == last_q);
  assign rx_raw_o  = sr_q;
  assign len_o     = len_q;
endmodule

// File: rtl/spi_pio_pack.sv
module spi_pio_pack
  import spi_pio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int BYTES = DATA_W / 8;

  // first received byte sits highest in raw_i; move it to byte 0
  always_comb begin
    word_o = '0;
    for (int k = 0; k < BYTES; k++) begin
      if (k <= int'(len_i)) word_o[8*k +: 8] = raw_i[8*(int'(len_i) - k) +: 8];
    end
  end
endmodule

// File: rtl/spi_pio_top.sv
module spi_pio_top
  import spi_pio_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int NUM_CS    = 2,
  parameter int CS_STRIDE = 4,
  parameter int WID_LSB   = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sck_o,
  output logic [NUM_CS-1:0] cs_no,
  output logic [IO_W-1:0]   io_o,
  output logic [IO_W-1:0]   io_oe_o,
  input  logic [IO_W-1:0]   io_i
);
  logic              busy, rx_mode, rx_done, tx_start, rx_start;
  cmd_t              start_cmd;
  logic [DATA_W-1:0] tx_word, rx_raw, rx_word;
  logic [LEN_W-1:0]  rx_len;

  spi_pio_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CS(NUM_CS),
    .CS_STRIDE(CS_STRIDE), .WID_LSB(WID_LSB)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .busy_i(busy), .rx_done_i(rx_done), .rx_word_i(rx_word),
    .tx_start_o(tx_start), .rx_start_o(rx_start),
    .start_cmd_o(start_cmd), .tx_word_o(tx_word), .cs_no(cs_no)
  );

  spi_pio_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tx_start_i(tx_start), .rx_start_i(rx_start),
    .start_cmd_i(start_cmd), .tx_word_i(tx_word), .io_i(io_i),
    .sck_o(sck_o), .io_o(io_o), .io_oe_o(io_oe_o),
    .busy_o(busy), .rx_mode_o(rx_mode), .rx_done_o(rx_done),
    .rx_raw_o(rx_raw), .len_o(rx_len)
  );

  spi_pio_pack #(.DATA_W(DATA_W)) u_pack (
    .raw_i(rx_raw), .len_i(rx_len), .word_o(rx_word)
  );
endmodule

// File: rtl/spi_pio_chk.sv
module spi_pio_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sck_i,
  input logic [3:0] io_oe_i,
  input logic       busy_i,
  input logic       rx_i
);
  a_r5_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sck_i);

  a_r5_sck_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> (sck_i != $past(sck_i)));

  a_r6_rise_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_i) |-> busy_i);

  a_r4_oe_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_i == 4'b0000) || (io_oe_i == 4'b0001) ||
    (io_oe_i == 4'b0011) || (io_oe_i == 4'b1111));

  a_r7_oe_off_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_i || !busy_i) |-> (io_oe_i == 4'b0000));

  a_r9_mode_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(rx_i) && $stable(io_oe_i)));
endmodule

bind spi_pio_top spi_pio_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_o),
  .io_oe_i(io_oe_o), .busy_i(busy), .rx_i(rx_mode)
);

// File: tb/tb_spi_pio_top.sv
module tb_spi_pio_top;
  localparam logic [4:0] A_CS = 5'h00, A_WCMD = 5'h04, A_RCMD = 5'h08,
                         A_WDATA = 5'h0C, A_RDATA = 5'h10, A_STATUS = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = A_STATUS;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck;
  logic [1:0]  cs_n;
  logic [3:0]  io_o, io_oe, io_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_pio_top dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .sck_o(sck),
    .cs_no(cs_n), .io_o(io_o), .io_oe_o(io_oe), .io_i(io_i)
  );

  // reference model state
  bit          m_busy, m_rx;
  int          m_cyc, m_total, m_lanes, m_len;
  logic [31:0] m_word, m_pat, m_rdata, m_wcmd, m_rcmd;
  logic [1:0]  m_cs;

  function automatic int lanes_of(logic [31:0] c);
    case (c[29:28])
      2'd0: return 1;
      2'd1: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [3:0] slot_bits(logic [31:0] w, int slot, int l);
    logic [31:0] t;
    t = w >> (32 - (slot + 1) * l);
    return 4'(t & ((32'd1 << l) - 1));
  endfunction

  task automatic start(logic [31:0] c, bit rx);
    m_busy  = 1;
    m_rx    = rx;
    m_cyc   = 0;
    m_lanes = lanes_of(c);
    m_len   = int'(c[1:0]) + 1;
    m_total = 2 * m_len * 8 / m_lanes;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_rx = 0; m_cyc = 0; m_total = 0; m_lanes = 1; m_len = 1;
      m_word = '0; m_rdata = '0; m_wcmd = '0; m_rcmd = '0; m_cs = 2'b11;
    end else begin
      bit bb;
      bb = m_busy;
      if (m_busy) begin
        m_cyc++;
        if (m_cyc == m_total) begin
          m_busy = 0;
          if (m_rx) begin
            m_rdata = '0;
            for (int k = 0; k < m_len; k++) m_rdata[8*k +: 8] = m_pat[31-8*k -: 8];
          end
        end
      end
      if (reg_wr) begin
        case (reg_addr)
          A_CS:   m_cs = {reg_wdata[4], reg_wdata[0]};
          A_WCMD: if (!bb) m_wcmd = reg_wdata & 32'h3000_0003;
          A_RCMD: if (!bb) begin
            m_rcmd = reg_wdata & 32'h3000_0003;
            start(m_rcmd, 1);
          end
          A_WDATA: if (!bb) begin
            m_word = reg_wdata;
            start(m_wcmd, 0);
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // flash-side drive and per-cycle comparison
  always @(negedge clk) begin
    logic [3:0] b, eoe, eio;
    logic [31:0] ecs;
    int s;
    s = m_cyc / 2;
    io_i = 4'b1010;
    if (m_busy && m_rx) begin
      b = slot_bits(m_pat, s, m_lanes);
      if (m_lanes == 1) io_i = {2'b10, b[0], ~b[0]};
      else if (m_lanes == 2) io_i = {2'b01, b[1:0]};
      else io_i = b;
    end
    #1;
    if (rst_n && !done) begin
      eoe = 4'b0000;
      eio = 4'b0000;
      if (m_busy && !m_rx) begin
        eoe = (m_lanes == 1) ? 4'b0001 : (m_lanes == 2) ? 4'b0011 : 4'b1111;
        eio = slot_bits(m_word, s, m_lanes);
      end
      chk(sck == (m_busy && m_cyc[0]), "R5 sck", 32'(sck), 32'(m_busy && m_cyc[0]));
      chk(io_oe == eoe, (m_busy && m_rx) ? "R7 oe" : "R4 oe", 32'(io_oe), 32'(eoe));
      if (eoe != 0) chk(io_o == eio, "R3 io_o", 32'(io_o), 32'(eio));
      chk(cs_n == m_cs, "R2 cs", 32'(cs_n), 32'(m_cs));
      if (!reg_wr) begin
        case (reg_addr)
          A_STATUS: chk(reg_rdata == (32'(m_busy) << 3), "R6 status", reg_rdata, 32'(m_busy) << 3);
          A_RDATA:  chk(reg_rdata == m_rdata, "R8 rdata", reg_rdata, m_rdata);
          A_WCMD:   chk(reg_rdata == m_wcmd, "R10 wcmd", reg_rdata, m_wcmd);
          A_RCMD:   chk(reg_rdata == m_rcmd, "R10 rcmd", reg_rdata, m_rcmd);
          A_CS: begin
            ecs = '1; ecs[0] = m_cs[0]; ecs[4] = m_cs[1];
            chk(reg_rdata == ecs, "R2 cs readback", reg_rdata, ecs);
          end
          default: ;
        endcase
      end
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = A_STATUS;
  endtask

  task automatic rd(logic [4:0] a);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    reg_addr = A_STATUS;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic do_tx(logic [31:0] cmd, logic [31:0] d);
    wr(A_WCMD, cmd);
    wr(A_WDATA, d);
    wait_idle();
  endtask

  task automatic do_rx(logic [31:0] cmd, logic [31:0] pat);
    m_pat = pat;
    wr(A_RCMD, cmd);
    wait_idle();
    rd(A_RDATA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 2'b11, "R1 cs", 32'(cs_n), 32'h3);
    chk(sck == 1'b0, "R1 sck", 32'(sck), 32'h0);
    chk(io_oe == 4'b0, "R1 oe", 32'(io_oe), 32'h0);
    chk(reg_rdata == 32'h0, "R1 status", reg_rdata, 32'h0);
    reg_addr = A_RDATA;
    #1 chk(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 32'h0);
    reg_addr = A_STATUS;
    @(negedge clk);
    rst_n = 1'b1;

    wr(A_CS, 32'hFFFF_FFFE);              // R2 select device 0
    rd(A_CS);
    do_tx(32'h0000_0000, 32'hA5FF_FFFF);  // R3 single, 1 byte
    do_tx(32'h1000_0003, 32'h1234_5678);  // R4 dual, 4 bytes
    do_tx(32'h2000_0002, 32'h9C3E_71FF);  // R4 quad, 3 bytes
    do_tx(32'h3000_0001, 32'h5AC3_0000);  // R4 code 3 quad, 2 bytes
    rd(A_WCMD);                           // R10
    do_rx(32'h0000_0003, 32'hC35A_0F81);  // R7 single read, 4 bytes
    do_rx(32'h1000_0001, 32'h6B94_0000);  // R8 dual, 2 bytes
    do_rx(32'h2000_0000, 32'hE700_0000);  // R8 quad, 1 byte
    do_rx(32'hF000_0FF3, 32'h0123_4567);  // R10 masked fields, quad 4 bytes
    rd(A_RCMD);

    // R9 writes during a burst are ignored; R2 cs changes during burst
    wr(A_WCMD, 32'h0000_0003);
    wr(A_WDATA, 32'hF0F0_3C3C);
    wr(A_WCMD, 32'h2000_0000);
    wr(A_WDATA, 32'h0000_0000);
    wr(A_RCMD, 32'h1000_0000);
    wr(A_CS, 32'hFFFF_FFEF);
    wait_idle();
    rd(A_WCMD);
    rd(A_RCMD);
    rd(A_RDATA);
    rd(A_CS);
    do_tx(32'h0000_0001, 32'h8001_0000);  // R3 still works after ignored writes
    wr(A_CS, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R6 actual=busy expected=idle");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule